// File: doc/BRIEF.md
# Selective Scan-Slice Decoder

This block rebuilds full-width scan slices for a set of internal scan chains from a stream of short slice-codes. Each code is K+2 bits wide. A 2-bit control field chooses how the code is read, and a K-bit data field carries a bit index or a literal group value. Each slice starts with a background value of all zeros or all ones. Only the minority bits are then marked: either one bit at a time, or by copying a K-bit literal over a group of adjacent bits.

A code that starts a new slice closes the slice that is open and sends it to the chains with a one-cycle valid strobe. A flush input closes the last slice of a pattern in the same way. The data width K follows from the number of chains N, so one parameter sizes the whole block.

Top module: `scan_slice_expander`

## Requirements
- R1: K equals ceil(log2(N+1)). A code has its control field in bits [K+1:K] and its data field in bits [K-1:0]. Slice bit index i (0 to N-1) appears on slice_out[N-1-i], so index 0 is the leftmost bit.
- R2: Control 00 opens a new slice with all bits 0 and sets the bit named by the data field to 1. A data value of N or more leaves every bit at 0.
- R3: Control 01 opens a new slice with all bits 1 and clears the bit named by the data field to 0. A data value of N or more leaves every bit at 1.
- R4: Control 10 on an open slice sets the indexed bit to the complement of that slice's background value. A data value of N or more changes nothing.
- R5: Two consecutive control-11 codes on an open slice form one group copy. The first data field is a start index s. In the second, data bit K-1-j is written to index s+j for j from 0 to K-1. Any index above N-1 is dropped.
- R6: A control 00 or 01 code that arrives while a slice is open emits the accumulated slice. slice_valid is high for the single cycle after the code's clock edge, and slice_out keeps its value until the next emission.
- R7: flush with code_valid low emits the open slice and closes it. flush with no open slice, or in the same cycle as a valid code, has no effect.
- R8: Control 10 and 11 codes that arrive while no slice is open are ignored.
- R9: A code other than control 11 that arrives while a group copy is waiting for its second code abandons that group copy and is processed normally.
- R10: After reset, slice_valid and slice_out are 0 and no slice is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | code_in holds a slice-code this cycle |
| code_in | input | K+2 | Slice-code: control in [K+1:K], data in [K-1:0] |
| flush | input | 1 | Close and emit the open slice |
| slice_valid | output | 1 | One-cycle strobe for a finished slice |
| slice_out | output | N | Last emitted slice, index 0 in the MSB |

## Verification
The assertions check on every cycle that each emission was caused by a starting code or by a lone flush. They also check that slice_out only moves together with the strobe, that a starting code leaves at most one bit different from the background, that a pending group copy only exists inside an open slice, and that codes arriving while no slice is open leave the state alone. The actual bit placement of single-bit and group-copy codes, the dropping of group bits past the end, null indices, and abandoned group copies can only be shown by the bench's sweeps. Those sweeps compare every emitted slice against values the bench computes itself.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
   typedef enum logic [1:0] {
      CT_NEW0  = 2'b00,
      CT_NEW1  = 2'b01,
      CT_FLIP  = 2'b10,
      CT_GROUP = 2'b11
   } ctrl_e;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_START,
      OP_FLIP,
      OP_GRP_ARM,
      OP_GRP_WRITE,
      OP_FLUSH
   } op_e;
endpackage

// File: rtl/ssx_decode.sv
module ssx_decode
   import ssx_pkg::*;
#(
   parameter int K = 4
) (
   input  logic         code_valid,
   input  logic [K+1:0] code,
   input  logic         flush,
   input  logic         slice_open,
   input  logic         grp_pend,
   output op_e          op,
   output logic         new_fill
);
   ctrl_e ctrl;

   always_comb begin
      ctrl     = ctrl_e'(code[K+1:K]);
      new_fill = code[K];
      op       = OP_IDLE;
      if (code_valid) begin
         case (ctrl)
            CT_NEW0, CT_NEW1: op = OP_START;
            CT_FLIP:          op = slice_open ? OP_FLIP : OP_IDLE;
            CT_GROUP:         op = !slice_open ? OP_IDLE :
                                   (grp_pend ? OP_GRP_WRITE : OP_GRP_ARM);
            default:          op = OP_IDLE;
         endcase
      end else if (flush && slice_open) begin
         op = OP_FLUSH;
      end
   end
endmodule

// File: rtl/ssx_accum.sv
module ssx_accum
   import ssx_pkg::*;
#(
   parameter int N = 8,
   parameter int K = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  op_e          op,
   input  logic         new_fill,
   input  logic [K-1:0] data,
   output logic [N-1:0] acc_q,
   output logic         slice_open,
   output logic         grp_pend,
   output logic         emit
);
   logic [N-1:0] acc_d;
   logic         fill_q, fill_d;
   logic         open_q, open_d;
   logic         pend_q, pend_d;
   logic [K-1:0] start_q, start_d;
   logic [N-1:0] idx_hit;
   logic [N-1:0] grp_hit;
   logic [N-1:0] grp_bit;

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign idx_hit[i] = (data == K'(i));

      always_comb begin
         grp_hit[i] = 1'b0;
         grp_bit[i] = 1'b0;
         for (int j = 0; j < K; j++) begin
            if (int'(start_q) + j == i) begin
               grp_hit[i] = 1'b1;
               grp_bit[i] = data[K-1-j];
            end
         end
      end
   end

   always_comb begin
      acc_d   = acc_q;
      fill_d  = fill_q;
      open_d  = open_q;
      pend_d  = pend_q;
      start_d = start_q;
      emit    = 1'b0;
      case (op)
         OP_START: begin
            emit   = open_q;
            fill_d = new_fill;
            open_d = 1'b1;
            pend_d = 1'b0;
            for (int i = 0; i < N; i++)
               acc_d[N-1-i] = idx_hit[i] ? ~new_fill : new_fill;
         end
         OP_FLIP: begin
            pend_d = 1'b0;
            for (int i = 0; i < N; i++)
               if (idx_hit[i]) acc_d[N-1-i] = ~fill_q;
         end
         OP_GRP_ARM: begin
            pend_d  = 1'b1;
            start_d = data;
         end
         OP_GRP_WRITE: begin
            pend_d = 1'b0;
            for (int i = 0; i < N; i++)
               if (grp_hit[i]) acc_d[N-1-i] = grp_bit[i];
         end
         OP_FLUSH: begin
            emit   = 1'b1;
            open_d = 1'b0;
            pend_d = 1'b0;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         fill_q  <= 1'b0;
         open_q  <= 1'b0;
         pend_q  <= 1'b0;
         start_q <= '0;
      end else begin
         acc_q   <= acc_d;
         fill_q  <= fill_d;
         open_q  <= open_d;
         pend_q  <= pend_d;
         start_q <= start_d;
      end
   end

   assign slice_open = open_q;
   assign grp_pend   = pend_q;
endmodule

// File: rtl/ssx_emit.sv
module ssx_emit #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         emit,
   input  logic [N-1:0] acc_q,
   output logic         slice_valid,
   output logic [N-1:0] slice_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slice_valid <= 1'b0;
         slice_out   <= '0;
      end else begin
         slice_valid <= emit;
         if (emit) slice_out <= acc_q;
      end
   end
endmodule

// File: rtl/scan_slice_expander.sv
module scan_slice_expander
   import ssx_pkg::*;
#(
   parameter int N = 8,
   parameter int K = $clog2(N + 1),
   localparam int C = K + 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         code_valid,
   input  logic [C-1:0] code_in,
   input  logic         flush,
   output logic         slice_valid,
   output logic [N-1:0] slice_out
);
   if (N < 2) begin : g_bad_n
      $error("scan_slice_expander: N must be at least 2");
   end
   if (K != $clog2(N + 1)) begin : g_bad_k
      $error("scan_slice_expander: K must equal ceil(log2(N+1))");
   end

   op_e          op;
   logic         new_fill;
   logic [N-1:0] acc_q;
   logic         slice_open;
   logic         grp_pend;
   logic         emit;

   ssx_decode #(.K(K)) u_decode (
      .code_valid (code_valid),
      .code       (code_in),
      .flush      (flush),
      .slice_open (slice_open),
      .grp_pend   (grp_pend),
      .op         (op),
      .new_fill   (new_fill)
   );

   ssx_accum #(.N(N), .K(K)) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .new_fill   (new_fill),
      .data       (code_in[K-1:0]),
      .acc_q      (acc_q),
      .slice_open (slice_open),
      .grp_pend   (grp_pend),
      .emit       (emit)
   );

   ssx_emit #(.N(N)) u_emit (
      .clk         (clk),
      .rst_n       (rst_n),
      .emit        (emit),
      .acc_q       (acc_q),
      .slice_valid (slice_valid),
      .slice_out   (slice_out)
   );
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker #(
   parameter int N = 8,
   parameter int K = 4
) (
   input logic         clk,
   input logic         rst_n,
   input logic         code_valid,
   input logic [K+1:0] code_in,
   input logic         flush,
   input logic         slice_valid,
   input logic [N-1:0] slice_out,
   input logic [N-1:0] acc_q,
   input logic         slice_open,
   input logic         grp_pend
);
   AST_EMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      slice_valid |-> ($past(code_valid && !code_in[K+1]) || $past(flush && !code_valid))); // R6
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !slice_valid |-> $stable(slice_out)); // R6
   AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && code_in[K+1:K] == 2'b00) |=> ($countones(acc_q) <= 1)); // R2
   AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && code_in[K+1:K] == 2'b01) |=> ($countones(~acc_q) <= 1)); // R3
   AST_PEND_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      grp_pend |-> slice_open); // R5
   AST_CLOSED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid && code_in[K+1] && !slice_open) |=> ($stable(acc_q) && !slice_open)); // R8
   AST_FLUSH_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !code_valid) |=> !slice_open); // R7
endmodule

bind scan_slice_expander ssx_checker #(.N(N), .K(K)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .code_valid  (code_valid),
   .code_in     (code_in),
   .flush       (flush),
   .slice_valid (slice_valid),
   .slice_out   (slice_out),
   .acc_q       (acc_q),
   .slice_open  (slice_open),
   .grp_pend    (grp_pend)
);

// File: tb/tb_scan_slice_expander.sv
module tb_scan_slice_expander;
   localparam int N = 8;
   localparam int K = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         code_valid = 1'b0;
   logic [K+1:0] code_in = '0;
   logic         flush = 1'b0;
   logic         slice_valid;
   logic [N-1:0] slice_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [N-1:0] m;
   logic [N-1:0] last_out = '0;
   bit           mfill = 1'b0, mopen = 1'b0, mpend = 1'b0;
   int           mstart = 0;

   always #10 clk = ~clk;

   scan_slice_expander #(.N(N)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .code_valid  (code_valid),
      .code_in     (code_in),
      .flush       (flush),
      .slice_valid (slice_valid),
      .slice_out   (slice_out)
   );

   task automatic check(input string tag, input string what, input logic [N-1:0] act,
                        input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   // Drive one cycle at a negedge, predict from the requirements, sample at the next negedge.
   task automatic step(input string tag, input bit v, input logic [1:0] ctl, input int d,
                       input bit fl);
      bit           e_v = 1'b0;
      logic [N-1:0] e_o = m;
      code_valid = v;
      code_in    = {ctl, K'(d)};
      flush      = fl;
      if (v) begin
         if (ctl[1] == 1'b0) begin                // R2 R3 R6
            e_v   = mopen;
            mfill = ctl[0];
            m     = {N{ctl[0]}};
            if (d < N) m[N-1-d] = ~ctl[0];
            mopen = 1'b1;
            mpend = 1'b0;
         end else if (mopen && ctl == 2'b10) begin // R4 R9
            if (d < N) m[N-1-d] = ~mfill;
            mpend = 1'b0;
         end else if (mopen && ctl == 2'b11) begin // R5
            if (!mpend) begin
               mstart = d;
               mpend  = 1'b1;
            end else begin
               for (int j = 0; j < K; j++)
                  if (mstart + j < N) m[N-1-mstart-j] = d[K-1-j];
               mpend = 1'b0;
            end
         end
      end else if (fl && mopen) begin             // R7
         e_v   = 1'b1;
         mopen = 1'b0;
         mpend = 1'b0;
      end
      @(negedge clk);
      code_valid = 1'b0;
      flush      = 1'b0;
      check(tag, "slice_valid", N'(slice_valid), N'(e_v));
      if (e_v) begin
         check(tag, "slice_out", slice_out, e_o);
         last_out = e_o;
      end else begin
         check(tag, "slice_out held", slice_out, last_out);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R6 actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      m = '0;
      repeat (3) @(negedge clk);
      check("R10", "slice_valid at reset", N'(slice_valid), '0);
      check("R10", "slice_out at reset", slice_out, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: continuation codes with no open slice; R7: flush with no open slice
      step("R8", 1, 2'b10, 5, 0);
      step("R8", 1, 2'b11, 0, 0);
      step("R8", 1, 2'b11, 15, 0);
      step("R7", 0, 2'b00, 0, 1);

      // R1 R2 R3: every start code, both backgrounds, every data value incl. null
      for (int f = 0; f < 2; f++)
         for (int d = 0; d < 16; d++) begin
            step(f ? "R1 R3" : "R1 R2", 1, {1'b0, f[0]}, d, 0);
            step("R7", 0, 2'b00, 0, 1);
         end

      // R4: single-bit codes on a 1 background and on a 0 background
      for (int a = 0; a <= N; a++)
         for (int b = 0; b < 16; b++) begin
            step("R4", 1, {1'b0, a[0]}, a, 0);
            step("R4", 1, 2'b10, b, 0);
            step("R4", 0, 2'b00, 0, 1);
         end

      // R5: every start index and literal, including groups that run past N-1
      for (int s = 0; s < 16; s++)
         for (int lit = 0; lit < 16; lit++) begin
            step("R5", 1, {1'b0, s[1]}, N, 0);
            step("R5", 1, 2'b11, s, 0);
            step("R5", 1, 2'b11, lit, 0);
            step("R5", 0, 2'b00, 0, 1);
         end

      // R6: back-to-back start codes each emit the previous slice
      step("R6", 1, 2'b00, 1, 0);
      step("R6", 1, 2'b01, 2, 0);
      step("R6", 1, 2'b00, N, 0);
      step("R6", 1, 2'b01, 7, 0);
      step("R6", 0, 2'b00, 0, 1);

      // R9: group copy abandoned by a single-bit code, then a fresh group copy
      step("R9", 1, 2'b00, N, 0);
      step("R9", 1, 2'b11, 2, 0);
      step("R9", 1, 2'b10, 3, 0);
      step("R9", 1, 2'b11, 4, 0);
      step("R9", 1, 2'b11, 15, 0);
      step("R9", 0, 2'b00, 0, 1);
      step("R9", 1, 2'b01, N, 0);
      step("R9", 1, 2'b11, 0, 0);
      step("R9", 1, 2'b00, 6, 0);
      step("R9", 1, 2'b11, 9, 0);
      step("R9", 0, 2'b00, 0, 1);

      // R7: flush together with a valid code has no effect
      step("R7", 1, 2'b00, 0, 0);
      step("R7", 1, 2'b10, 7, 1);
      step("R7", 1, 2'b00, 3, 1);
      step("R7", 0, 2'b00, 0, 1);
      step("R7", 0, 2'b00, 0, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule